// File: doc/BRIEF.md
# Two-Instruction 64-bit Integer Core

This block is a small multi-cycle 64-bit integer core that understands exactly two operations of the open RISC-V base integer set: register-register addition (ADD) and register-immediate addition (ADDI). The core has 32 general registers of 64 bits each and a program counter. Its program lives in a byte-addressed instruction store. While the core is idle or halted, that store is written one byte per clock through a load port.

A one-cycle start pulse latches the program length in bytes and resets the PC to zero. The core then repeats a two-cycle loop. In the fetch cycle it assembles four bytes little-endian, latches the instruction and advances the PC by four. In the execute cycle it decodes the instruction and writes the sum back. Any opcode other than the two supported ones is skipped silently. The core stops and raises its halted flag once the PC is no longer below the program length. A combinational debug port reads any register by index, so the results can be inspected after a run.

Top module: `tiny_add_core`

## Requirements
- R1: Register x0 always reads zero; an instruction that names x0 as destination leaves it at zero.
- R2: After reset the PC is 0, halted and busy are low, every register is zero except x2, which holds SP_INIT (default 134217728, the nominal memory size in bytes).
- R3: Each load cycle writes load_byte at load_addr. An instruction is the four bytes at PC..PC+3 taken little-endian, with the byte at PC as bits [7:0].
- R4: Each instruction takes two cycles (fetch, then execute) and advances the PC by 4. For a program of N instructions, halted is first high 2N+2 cycles after the cycle that carries start, and pc then reads 4N.
- R5: Opcode 0x13 in bits [6:0] (ADDI) writes rd (bits [11:7]) with rs1 (bits [19:15]) plus bits [31:20] sign-extended to 64 bits.
- R6: Opcode 0x33 (ADD) writes rd with rs1 plus rs2 (bits [24:20]).
- R7: Additions wrap modulo 2^64 with no flag or side effect.
- R8: Any other opcode changes no register; only the PC advance takes effect.
- R9: Execution stops with halted high and the PC frozen when PC is not below the latched program length; a length of 0 executes nothing.
- R10: Load writes presented while the core is running (busy high) are ignored.
- R11: dbg_data returns the register selected by dbg_idx combinationally, without a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_en | input | 1 | Write one program byte this cycle |
| load_addr | input | AW (8) | Byte address for the load write |
| load_byte | input | 8 | Byte value to write |
| prog_len | input | AW+1 (9) | Program length in bytes, latched at start |
| start | input | 1 | Begin execution from PC 0 (idle or halted only) |
| halted | output | 1 | Core has reached the end of the program |
| busy | output | 1 | Core is fetching or executing |
| pc | output | AW+1 (9) | Current program counter |
| dbg_idx | input | 5 | Register index for read-back |
| dbg_data | output | 64 | Value of the selected register |

## Verification
The embedded properties assume that prog_len never exceeds the store depth when start is taken, and that start is pulsed only while the core is idle or halted. The PC-step and halt properties rely on those limits to bound the PC. The bench only presents lengths that are multiples of four and no larger than the store. It holds start for a single cycle and pulses it only after halted has been seen. The one load issued during a run is deliberate: it checks that such writes are dropped.

// File: rtl/tac_pkg.sv
package tac_pkg;

   localparam logic [6:0] OPC_ADDI = 7'h13;
   localparam logic [6:0] OPC_ADD  = 7'h33;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_FETCH,
      ST_EXEC,
      ST_HALT
   } tac_state_e;

   typedef enum logic [1:0] {
      OP_NONE,
      OP_ADDI,
      OP_ADD
   } tac_op_e;

   typedef struct packed {
      tac_op_e    op;
      logic [4:0] rd;
      logic [4:0] rs1;
      logic [4:0] rs2;
      logic [11:0] imm;
   } tac_dec_t;

endpackage

// File: rtl/tac_imem.sv
module tac_imem #(
   parameter int unsigned DEPTH = 256,
   localparam int unsigned AW = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [7:0]    wbyte,
   input  logic [AW-1:0] raddr,
   output logic [31:0]   rword
);

   logic [7:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) begin
         mem[waddr] <= wbyte;
      end
   end

   // little-endian assembly: lane k holds the byte at raddr + k
   for (genvar k = 0; k < 4; k++) begin : g_lane
      assign rword[8*k +: 8] = mem[AW'(raddr + AW'(k))];
   end

endmodule

// File: rtl/tac_regfile.sv
module tac_regfile #(
   parameter int unsigned      XLEN    = 64,
   parameter int unsigned      NREG    = 32,
   parameter int unsigned      SP_IDX  = 2,
   parameter longint unsigned  SP_INIT = 64'd134217728,
   localparam int unsigned     IW      = $clog2(NREG)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            we,
   input  logic [IW-1:0]   wa,
   input  logic [XLEN-1:0] wd,
   input  logic [IW-1:0]   ra1,
   output logic [XLEN-1:0] rd1,
   input  logic [IW-1:0]   ra2,
   output logic [XLEN-1:0] rd2,
   input  logic [IW-1:0]   ra3,
   output logic [XLEN-1:0] rd3
);

   if (NREG != (1 << IW)) begin : g_bad_nreg
      $error("tac_regfile: NREG must be a power of two");
   end
   if (SP_IDX == 0 || SP_IDX >= NREG) begin : g_bad_sp
      $error("tac_regfile: SP_IDX out of range");
   end

   logic [XLEN-1:0] q [NREG];

   for (genvar i = 0; i < NREG; i++) begin : g_reg
      if (i == 0) begin : g_zero
         assign q[i] = '0;
      end else begin : g_flop
         localparam logic [XLEN-1:0] RST_VAL =
            (i == SP_IDX) ? XLEN'(SP_INIT) : '0;
         logic [XLEN-1:0] r;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               r <= RST_VAL;
            end else if (we && (wa == IW'(i))) begin
               r <= wd;
            end
         end
         assign q[i] = r;
      end
   end

   assign rd1 = q[ra1];
   assign rd2 = q[ra2];
   assign rd3 = q[ra3];

   // R5/R6: a write to a nonzero index lands in that register
   assert_reg_write_R5 : assert property (@(posedge clk) disable iff (!rst_n)
      (we && wa != '0) |=> (q[$past(wa)] == $past(wd)));

endmodule

// File: rtl/tac_decode.sv
module tac_decode
   import tac_pkg::*;
(
   input  logic [31:0] instr,
   output tac_dec_t    dec
);

   logic unused_funct3;
   assign unused_funct3 = ^instr[14:12];

   always_comb begin
      dec.rd  = instr[11:7];
      dec.rs1 = instr[19:15];
      dec.rs2 = instr[24:20];
      dec.imm = instr[31:20];
      unique case (instr[6:0])
         OPC_ADDI: dec.op = OP_ADDI;
         OPC_ADD:  dec.op = OP_ADD;
         default:  dec.op = OP_NONE;
      endcase
   end

endmodule

// File: rtl/tac_alu.sv
module tac_alu
   import tac_pkg::*;
#(
   parameter int unsigned XLEN = 64
) (
   input  tac_op_e         op,
   input  logic [XLEN-1:0] a,
   input  logic [XLEN-1:0] b_reg,
   input  logic [11:0]     imm,
   output logic [XLEN-1:0] sum
);

   logic [XLEN-1:0] imm_ext;
   logic [XLEN-1:0] b;

   assign imm_ext = {{(XLEN-12){imm[11]}}, imm};
   assign b       = (op == OP_ADDI) ? imm_ext : b_reg;
   // wraps modulo 2^XLEN, carry out dropped
   assign sum     = a + b;

endmodule

// File: rtl/tiny_add_core.sv
module tiny_add_core
   import tac_pkg::*;
#(
   parameter int unsigned     XLEN       = 64,
   parameter int unsigned     NREG       = 32,
   parameter int unsigned     IMEM_BYTES = 256,
   parameter longint unsigned SP_INIT    = 64'd134217728,
   localparam int unsigned    AW         = $clog2(IMEM_BYTES),
   localparam int unsigned    PW         = AW + 1,
   localparam int unsigned    SP_IDX     = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            load_en,
   input  logic [AW-1:0]   load_addr,
   input  logic [7:0]      load_byte,
   input  logic [PW-1:0]   prog_len,
   input  logic            start,
   output logic            halted,
   output logic            busy,
   output logic [PW-1:0]   pc,
   input  logic [4:0]      dbg_idx,
   output logic [XLEN-1:0] dbg_data
);

   if (IMEM_BYTES < 4 || (IMEM_BYTES & (IMEM_BYTES - 1)) != 0) begin : g_bad_depth
      $error("tiny_add_core: IMEM_BYTES must be a power of two of at least 4");
   end
   if (XLEN < 12) begin : g_bad_xlen
      $error("tiny_add_core: XLEN must hold a 12-bit immediate");
   end
   if (NREG != 32) begin : g_bad_nreg
      $error("tiny_add_core: register fields are 5 bits, NREG must be 32");
   end

   tac_state_e      state_q;
   logic [PW-1:0]   pc_q;
   logic [PW-1:0]   len_q;
   logic [31:0]     ir_q;
   logic [31:0]     fetch_word;
   tac_dec_t        dec;
   logic [XLEN-1:0] rs1_val;
   logic [XLEN-1:0] rs2_val;
   logic [XLEN-1:0] sum;
   logic            rf_we;
   logic            idle_like;
   logic            at_end;

   assign idle_like = (state_q == ST_IDLE) || (state_q == ST_HALT);
   assign at_end    = (pc_q >= len_q);

   tac_imem #(.DEPTH(IMEM_BYTES)) u_imem (
      .clk   (clk),
      .we    (load_en && idle_like),
      .waddr (load_addr),
      .wbyte (load_byte),
      .raddr (pc_q[AW-1:0]),
      .rword (fetch_word)
   );

   tac_decode u_dec (
      .instr (ir_q),
      .dec   (dec)
   );

   tac_regfile #(
      .XLEN    (XLEN),
      .NREG    (NREG),
      .SP_IDX  (SP_IDX),
      .SP_INIT (SP_INIT)
   ) u_rf (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (rf_we),
      .wa    (dec.rd),
      .wd    (sum),
      .ra1   (dec.rs1),
      .rd1   (rs1_val),
      .ra2   (dec.rs2),
      .rd2   (rs2_val),
      .ra3   (dbg_idx),
      .rd3   (dbg_data)
   );

   tac_alu #(.XLEN(XLEN)) u_alu (
      .op    (dec.op),
      .a     (rs1_val),
      .b_reg (rs2_val),
      .imm   (dec.imm),
      .sum   (sum)
   );

   assign rf_we = (state_q == ST_EXEC) && (dec.op != OP_NONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         pc_q    <= '0;
         len_q   <= '0;
         ir_q    <= '0;
      end else begin
         unique case (state_q)
            ST_IDLE, ST_HALT: begin
               if (start) begin
                  pc_q    <= '0;
                  len_q   <= prog_len;
                  state_q <= ST_FETCH;
               end
            end
            ST_FETCH: begin
               if (at_end) begin
                  state_q <= ST_HALT;
               end else begin
                  ir_q    <= fetch_word;
                  pc_q    <= PW'(pc_q + PW'(4));
                  state_q <= ST_EXEC;
               end
            end
            ST_EXEC: begin
               state_q <= ST_FETCH;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign halted = (state_q == ST_HALT);
   assign busy   = !idle_like;
   assign pc     = pc_q;

   // R4: a fetch below the end moves the PC by exactly four
   assert_pc_step_R4 : assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_FETCH && !at_end) |=> (pc_q == $past(pc_q) + PW'(4)));

   // R9: a fetch at or past the length ends the run
   assert_halt_enter_R9 : assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_FETCH && at_end) |=> halted);

   // R9: without a new start the halted core stays put
   assert_halt_hold_R9 : assert property (@(posedge clk) disable iff (!rst_n)
      (halted && !start) |=> (halted && $stable(pc_q)));

   // R9: the length taken at start never exceeds the store
   assert_len_fits_R9 : assert property (@(posedge clk) disable iff (!rst_n)
      (idle_like && start) |-> (prog_len <= PW'(IMEM_BYTES)));

endmodule

// File: tb/tiny_add_core_tb.sv
module tiny_add_core_tb;

   localparam int unsigned     AW  = 8;
   localparam int unsigned     PW  = 9;
   localparam longint unsigned SP  = 64'd134217728;
   localparam logic [63:0]     ONES = '1;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            load_en = 1'b0;
   logic [AW-1:0]   load_addr = '0;
   logic [7:0]      load_byte = '0;
   logic [PW-1:0]   prog_len = '0;
   logic            start = 1'b0;
   logic            halted;
   logic            busy;
   logic [PW-1:0]   pc;
   logic [4:0]      dbg_idx = '0;
   logic [63:0]     dbg_data;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   tiny_add_core #(.IMEM_BYTES(256), .SP_INIT(SP)) u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_en   (load_en),
      .load_addr (load_addr),
      .load_byte (load_byte),
      .prog_len  (prog_len),
      .start     (start),
      .halted    (halted),
      .busy      (busy),
      .pc        (pc),
      .dbg_idx   (dbg_idx),
      .dbg_data  (dbg_data)
   );

   // single-instruction vectors; register state carries over between rows
   localparam int NV = 12;
   localparam logic [6:0]  V_OPC [NV] = '{7'h13, 7'h13, 7'h33, 7'h13, 7'h13, 7'h33,
                                          7'h13, 7'h13, 7'h03, 7'h3B, 7'h13, 7'h33};
   localparam logic [11:0] V_IMM [NV] = '{12'd5, 12'hFFF, 12'd5, 12'h7FF, 12'h800, 12'd9,
                                          12'd7, 12'hFF0, 12'd1, 12'd5, 12'd1, 12'd5};
   localparam logic [4:0]  V_RS1 [NV] = '{5'd0, 5'd0, 5'd6, 5'd0, 5'd0, 5'd8,
                                          5'd5, 5'd2, 5'd5, 5'd5, 5'd10, 5'd5};
   localparam logic [4:0]  V_RD  [NV] = '{5'd5, 5'd6, 5'd7, 5'd8, 5'd9, 5'd10,
                                          5'd0, 5'd11, 5'd12, 5'd13, 5'd15, 5'd5};
   localparam logic [63:0] V_EXP [NV] = '{64'd5, ONES, 64'd4, 64'h7FF,
                                          64'hFFFF_FFFF_FFFF_F800, ONES,
                                          64'd0, SP - 64'd16, 64'd0, 64'd0,
                                          64'd0, 64'd10};
   // R5 immediate rows, R7 wrap rows, R6 add rows, R1 x0 row, R2 stack row, R8 unknown rows
   localparam int          V_REQ [NV] = '{5, 5, 7, 5, 5, 6, 1, 2, 8, 8, 7, 6};

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic peek(input logic [4:0] idx, output logic [63:0] val);
      dbg_idx = idx;
      #1;
      val = dbg_data;
   endtask

   task automatic put_word(input logic [AW-1:0] addr, input logic [31:0] w);
      for (int k = 0; k < 4; k++) begin
         @(negedge clk);
         load_en   = 1'b1;
         load_addr = AW'(addr + AW'(k));
         load_byte = w[8*k +: 8];
      end
      @(negedge clk);
      load_en = 1'b0;
   endtask

   function automatic logic [31:0] enc(input logic [6:0] opc, input logic [11:0] imm,
                                       input logic [4:0] rs1, input logic [4:0] rd);
      return {imm, rs1, 3'b000, rd, opc};
   endfunction

   // returns cycles from the start cycle until halted is seen
   task automatic run(input logic [PW-1:0] len, input bit poke, output int cnt);
      @(negedge clk);
      prog_len = len;
      start    = 1'b1;
      @(negedge clk);
      start = 1'b0;
      cnt   = 1;
      if (poke) begin
         load_en   = 1'b1;
         load_addr = 8'd8;
         load_byte = 8'h00;
      end
      @(negedge clk);
      load_en = 1'b0;
      cnt = 2;
      while (!halted && cnt < 500) begin
         @(negedge clk);
         cnt++;
      end
   endtask

   initial begin
      #800000;
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      logic [63:0] v;
      int cnt;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R2 reset state
      check("R2 halted", 64'(halted), 64'd0);
      check("R2 busy", 64'(busy), 64'd0);
      check("R2 pc", 64'(pc), 64'd0);
      peek(5'd2, v);  check("R2 x2", v, SP);
      peek(5'd1, v);  check("R2 x1", v, 64'd0);
      peek(5'd31, v); check("R2 x31", v, 64'd0);

      // vector table: one instruction at address 0, length 4
      for (int i = 0; i < NV; i++) begin
         put_word(8'd0, enc(V_OPC[i], V_IMM[i], V_RS1[i], V_RD[i]));
         run(9'd4, 1'b0, cnt);
         check($sformatf("R4 vec%0d cycles", i), 64'(cnt), 64'd4);
         peek(V_RD[i], v);
         check($sformatf("R%0d vec%0d", V_REQ[i], i), v, V_EXP[i]);
      end

      // R3 R5 R6 main three-instruction program
      put_word(8'd0, enc(7'h13, 12'd5, 5'd0, 5'd29));
      put_word(8'd4, enc(7'h13, 12'd37, 5'd0, 5'd30));
      put_word(8'd8, enc(7'h33, 12'd29, 5'd30, 5'd31));
      run(9'd12, 1'b0, cnt);
      check("R4 three-instr cycles", 64'(cnt), 64'd8);
      check("R4 pc at end", 64'(pc), 64'd12);
      check("R9 halted", 64'(halted), 64'd1);
      peek(5'd29, v); check("R5 x29", v, 64'd5);
      peek(5'd30, v); check("R11 x30", v, 64'd37);
      peek(5'd31, v); check("R6 x31", v, 64'd42);

      // R10 load during a run must not reach the store
      put_word(8'd8, enc(7'h33, 12'd29, 5'd30, 5'd14));
      run(9'd12, 1'b1, cnt);
      peek(5'd14, v); check("R10 x14", v, 64'd42);

      // R9 length 0 runs nothing
      run(9'd0, 1'b0, cnt);
      check("R9 zero-len cycles", 64'(cnt), 64'd2);
      check("R9 zero-len pc", 64'(pc), 64'd0);

      // R9 length 8 stops before the third word
      put_word(8'd8, enc(7'h33, 12'd29, 5'd30, 5'd17));
      run(9'd8, 1'b0, cnt);
      check("R9 short cycles", 64'(cnt), 64'd6);
      check("R9 short pc", 64'(pc), 64'd8);
      peek(5'd17, v); check("R9 x17 untouched", v, 64'd0);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule